// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked stand-in for a retriggerable monostable. Each channel watches three asynchronous inputs: a falling-edge trigger, a rising-edge trigger and an active-low clear. Every input is brought onto the system clock through a two-flop synchroniser and then edge-detected. An accepted trigger loads a down-counter with a fixed cycle count. The true output stays high while that count is nonzero, and the inverted output always shows its complement.

A trigger that arrives while a pulse is running reloads the counter, so the pulse stretches to the full width measured from the latest accepted trigger. For a few cycles after each accepted trigger a lockout window throws trigger events away. Holding clear low drops the pulse at once and blocks every trigger. The rising edge of clear counts as a trigger too, provided the other two inputs are in their enabling levels. Any number of independent channels can be instantiated, and all of them use the same width and lockout parameters.

Top module: `retrig_oneshot`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every `q_o` bit is 0 and every `q_n_o` bit is 1.
- R2: If the falling-edge input goes from 1 to 0 while the rising-edge input is 1 and clear is 1, `q_o` goes high after the third rising clock edge following the input change. It then stays high for exactly WIDTH_CYCLES clock cycles.
- R3: If the rising-edge input goes from 0 to 1 while the falling-edge input is 0 and clear is 1, a pulse of WIDTH_CYCLES cycles is produced.
- R4: A 0-to-1 change on clear triggers a WIDTH_CYCLES pulse only if the falling-edge input is 0 and the rising-edge input is 1. If the falling-edge input is 1, that change produces no pulse.
- R5: These input changes produce no pulse: a fall of the falling-edge input while the rising-edge input is 0, a rise of the rising-edge input while the falling-edge input is 1, a rise of the falling-edge input, and a fall of the rising-edge input.
- R6: An accepted trigger that arrives while `q_o` is high restarts the full interval. With two accepted triggers G cycles apart, the pulse lasts G + WIDTH_CYCLES cycles.
- R7: A trigger event evaluated within RETRIG_MIN cycles after an accepted trigger is discarded. The first event that can be accepted comes RETRIG_MIN + 1 cycles after it.
- R8: While the synchronised clear is 0, `q_o` is 0 one cycle later and no trigger is accepted. Clear ends a running pulse, with the same synchroniser latency as a trigger.
- R9: `q_n_o` is the complement of `q_o` in every cycle.
- R10: Each channel responds only to its own inputs. A trigger on one channel leaves the other channels' outputs unchanged.
- R11: When a clear rise and a rising-edge trigger are seen in the same cycle, exactly one trigger is accepted and one pulse of WIDTH_CYCLES results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fall_trig_i | input | NUM_CH | Per-channel trigger, active on falling edge |
| rise_trig_i | input | NUM_CH | Per-channel trigger, active on rising edge |
| clear_n_i | input | NUM_CH | Per-channel clear, active low; its rising edge can trigger |
| q_o | output | NUM_CH | Pulse output, high while timing |
| q_n_o | output | NUM_CH | Complement of `q_o` |

## Verification
The bench measures every pulse and compares its length with a queued expectation. Any pulse it did not expect counts as a failure, so a design that fires on a gated-off edge, on a clear rise with the wrong levels, or on a trigger presented while clear is low is caught. It retriggers at a gap of six cycles and again at a gap of two. A design that ignores retriggers produces a pulse that is too short, and a design with no lockout produces one that is too long. It pulls clear low in the middle of a pulse and expects a five-cycle pulse, which a design that lets the pulse finish would miss. It also presents a clear rise together with a trigger edge, and it triggers the second channel alone to show that the first channel does not respond.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;

  function automatic int cnt_bits(input int v);
    return (v < 1) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                din,
  output oneshot_pkg::edge_t  ev
);
  // stg[0], stg[1]: synchroniser; stg[2]: previous synchronised value
  logic [2:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {3{RST_VAL}};
    else     stg <= {stg[1:0], din};
  end

  always_comb begin
    ev.lvl  = stg[1];
    ev.rise = stg[1] & ~stg[2];
    ev.fall = ~stg[1] & stg[2];
  end
endmodule

// File: rtl/trig_decode.sv
module trig_decode (
  input  oneshot_pkg::edge_t a_ev,
  input  oneshot_pkg::edge_t b_ev,
  input  oneshot_pkg::edge_t c_ev,
  output logic               fire
);
  logic by_a, by_b, by_c;

  always_comb begin
    by_a = a_ev.fall & b_ev.lvl;
    by_b = b_ev.rise & ~a_ev.lvl;
    by_c = c_ev.rise & ~a_ev.lvl & b_ev.lvl;
    fire = c_ev.lvl & (by_a | by_b | by_c);
  end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int WIDTH_CYCLES = 20,
  parameter int RETRIG_MIN   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic clr_lvl,
  output logic q,
  output logic q_n
);
  localparam int CW = oneshot_pkg::cnt_bits(WIDTH_CYCLES);
  localparam int LW = oneshot_pkg::cnt_bits(RETRIG_MIN);
  localparam logic [CW-1:0] W_LOAD = CW'(WIDTH_CYCLES);
  localparam logic [LW-1:0] L_LOAD = LW'(RETRIG_MIN);

  logic [CW-1:0] cnt, cnt_nxt;
  logic [LW-1:0] lock, lock_nxt;
  logic          accept;

  always_comb begin
    accept = fire & clr_lvl & (lock == '0);
    if (!clr_lvl)         cnt_nxt = '0;
    else if (accept)      cnt_nxt = W_LOAD;
    else if (cnt != '0)   cnt_nxt = cnt - 1'b1;
    else                  cnt_nxt = cnt;
    if (!clr_lvl)         lock_nxt = '0;
    else if (accept)      lock_nxt = L_LOAD;
    else if (lock != '0)  lock_nxt = lock - 1'b1;
    else                  lock_nxt = lock;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      lock <= '0;
      q    <= 1'b0;
      q_n  <= 1'b1;
    end else begin
      cnt  <= cnt_nxt;
      lock <= lock_nxt;
      q    <= (cnt_nxt != '0);
      q_n  <= (cnt_nxt == '0);
    end
  end

  // R8
  clear_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_lvl |=> !q);

  // R2
  accept_sets_q_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> q);

  // R9
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    q != q_n);

  // R6
  fall_reason_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(q) |-> ($past(!clr_lvl) || ($past(cnt) == 1 && !$past(accept))));

  generate
    if (RETRIG_MIN > 0) begin : g_lock_chk
      // R7
      lockout_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);
    end
  endgenerate
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot #(
  parameter int NUM_CH       = 2,
  parameter int WIDTH_CYCLES = 20,
  parameter int RETRIG_MIN   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] fall_trig_i,
  input  logic [NUM_CH-1:0] rise_trig_i,
  input  logic [NUM_CH-1:0] clear_n_i,
  output logic [NUM_CH-1:0] q_o,
  output logic [NUM_CH-1:0] q_n_o
);
  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      oneshot_pkg::edge_t a_ev, b_ev, c_ev;
      logic fire;

      edge_sync #(.RST_VAL(1'b1)) u_sync_a (
        .clk(clk), .rst(rst), .din(fall_trig_i[ch]), .ev(a_ev));
      edge_sync #(.RST_VAL(1'b0)) u_sync_b (
        .clk(clk), .rst(rst), .din(rise_trig_i[ch]), .ev(b_ev));
      edge_sync #(.RST_VAL(1'b1)) u_sync_c (
        .clk(clk), .rst(rst), .din(clear_n_i[ch]), .ev(c_ev));

      trig_decode u_dec (
        .a_ev(a_ev), .b_ev(b_ev), .c_ev(c_ev), .fire(fire));

      pulse_timer #(
        .WIDTH_CYCLES(WIDTH_CYCLES),
        .RETRIG_MIN  (RETRIG_MIN)
      ) u_timer (
        .clk(clk), .rst(rst), .fire(fire), .clr_lvl(c_ev.lvl),
        .q(q_o[ch]), .q_n(q_n_o[ch]));
    end
  endgenerate
endmodule

// File: tb/retrig_oneshot_bench.sv
module retrig_oneshot_bench;
  localparam int W  = 12;
  localparam int RM = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] a, b, cl;
  logic [1:0] q, qn;

  int checks = 0;
  int failures = 0;
  int exp0[$];
  int exp1[$];
  int run_len[2];

  retrig_oneshot #(.NUM_CH(2), .WIDTH_CYCLES(W), .RETRIG_MIN(RM)) u_retrig_oneshot (
    .clk(clk), .rst(rst), .fall_trig_i(a), .rise_trig_i(b),
    .clear_n_i(cl), .q_o(q), .q_n_o(qn));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: measures each pulse and compares with the scoreboard
  initial begin
    run_len[0] = 0;
    run_len[1] = 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (qn !== ~q) chk("R9 complement", int'(qn), int'(~q));
      for (int ch = 0; ch < 2; ch++) begin
        if (q[ch]) run_len[ch]++;
        else if (run_len[ch] > 0) begin
          if (ch == 0) begin
            if (exp0.size() == 0) chk("R5/R8 unexpected pulse ch0", run_len[ch], 0);
            else chk("R2/R6 pulse length ch0", run_len[ch], exp0.pop_front());
          end else begin
            if (exp1.size() == 0) chk("R10 unexpected pulse ch1", run_len[ch], 0);
            else chk("R10 pulse length ch1", run_len[ch], exp1.pop_front());
          end
          run_len[ch] = 0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; a = 2'b11; b = 2'b00; cl = 2'b11;
    step(4);
    chk("R1 q during reset", int'(q), 0);
    chk("R1 q_n during reset", int'(qn), 3);
    rst = 1'b0;
    step(1);
    chk("R1 q after reset", int'(q), 0);
    step(4);

    // R5: A falls while B low, then B rises while A high
    a[0] = 1'b0; step(5);
    chk("R5 A fall with B low", int'(q[0]), 0);
    a[0] = 1'b1; step(4);
    b[0] = 1'b1; step(5);
    chk("R5 B rise with A high", int'(q[0]), 0);

    // R2: A falls while B high, latency and width
    a[0] = 1'b0; exp0.push_back(W);
    step(2); chk("R2 q before third edge", int'(q[0]), 0);
    step(1); chk("R2 q after third edge", int'(q[0]), 1);
    step(W + 4);
    a[0] = 1'b1; step(4);
    chk("R5 A rise", int'(q[0]), 0);

    // R3: B rises while A low
    b[0] = 1'b0; step(3);
    a[0] = 1'b0; step(4);
    chk("R5 B fall / A fall with B low", int'(q[0]), 0);
    b[0] = 1'b1; exp0.push_back(W);
    step(W + 6);

    // R6: retrigger at gap 6
    b[0] = 1'b0; step(4);
    b[0] = 1'b1; exp0.push_back(6 + W);
    step(2); b[0] = 1'b0;
    step(4); b[0] = 1'b1;
    step(W + 12);

    // R7: retrigger at gap 2 is discarded
    b[0] = 1'b0; step(4);
    b[0] = 1'b1; exp0.push_back(W);
    step(1); b[0] = 1'b0;
    step(1); b[0] = 1'b1;
    step(W + 6);

    // R8: clear ends pulse and inhibits
    b[0] = 1'b0; step(4);
    b[0] = 1'b1; exp0.push_back(5);
    step(5); cl[0] = 1'b0;
    step(4); chk("R8 clear ends pulse", int'(q[0]), 0);
    b[0] = 1'b0; step(3);
    b[0] = 1'b1; step(5);
    chk("R8 trigger while clear low", int'(q[0]), 0);

    // R4: clear rise with A low, B high triggers
    cl[0] = 1'b1; exp0.push_back(W);
    step(3); chk("R4 clear rise triggers", int'(q[0]), 1);
    step(W + 4);
    cl[0] = 1'b0; step(4);
    a[0] = 1'b1; step(4);
    cl[0] = 1'b1; step(6);
    chk("R4 clear rise with A high", int'(q[0]), 0);

    // R11: clear rise coincides with B rise
    cl[0] = 1'b0; a[0] = 1'b0; b[0] = 1'b0; step(4);
    cl[0] = 1'b1; b[0] = 1'b1; exp0.push_back(W);
    step(W + 6);

    // R10: channel 1 alone
    b[1] = 1'b1; step(4);
    a[1] = 1'b0; exp1.push_back(W);
    step(3);
    chk("R10 ch1 fires", int'(q[1]), 1);
    chk("R10 ch0 unaffected", int'(q[0]), 0);
    step(W + 4);

    chk("R2 all ch0 pulses seen", exp0.size(), 0);
    chk("R10 all ch1 pulses seen", exp1.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule